// File: doc/BRIEF.md
# Far-End Fault Code Detector

This block watches a recovered 100 Mbps serial bit stream, one bit on each cycle where the bit-valid input is high, for the far-end fault signalling pattern. One code unit is a run of exactly 84 ones closed by a single zero. When three such units arrive back to back, the block raises a live fault level. It keeps raising it for as long as correct units keep arriving. Any wrongly sized run drops the level.

Two management status bits are derived from the live level. The remote-fault bit latches high. The link-status bit latches low. A one-cycle read strobe, issued when software reads the status word, clears the latched remote-fault bit and lets the link bit recover. While the fault is still present, the remote-fault bit does not clear on a read, so every read of the status word reports the fault. Line decoding, signal detect and the register-bus protocol sit outside this block.

Top module: `fef_detector`

## Requirements
- R1: A synchronous active-high reset leaves fault_present low, remote_fault low and link_ok low.
- R2: On the clock edge that accepts the third consecutive good unit, fault_present goes high. A good unit is 84 accepted ones followed by an accepted zero. remote_fault goes high on the next edge and link_ok goes low on that same next edge.
- R3: Two good units on their own do not raise fault_present.
- R4: A zero that closes a run of fewer than 84 ones resets the good-unit count to zero, so three further good units are needed. A zero that directly follows another zero does the same.
- R5: The 85th consecutive accepted one clears fault_present on the edge that accepts it, and the zero that ends that run does not count as a good unit.
- R6: Cycles with bit_vld low are ignored. The bit_in value on those cycles neither breaks a run nor counts as a bit.
- R7: While fault_present is high, remote_fault stays high through every read strobe, so consecutive reads all return it set.
- R8: Once fault_present has dropped, remote_fault stays high until a read strobe, and it is low on the edge after that strobe.
- R9: link_ok is low on every edge that follows a cycle with fault_present high. It rises only on the edge after a read strobe taken while fault_present is low, and never without a read.
- R10: While fault_present is high, further good units keep it high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_vld | input | 1 | Qualifies bit_in for this cycle |
| bit_in | input | 1 | Recovered serial data bit |
| rd_stb | input | 1 | One-cycle strobe marking a read of the status word |
| fault_present | output | 1 | Live far-end fault indication |
| remote_fault | output | 1 | Latched-high remote-fault status bit |
| link_ok | output | 1 | Latched-low link-status bit, high means link up |

## Verification
fault_present is due on the first edge after the closing zero of the third unit. An overlong run drops it on the edge that accepts the 85th one. remote_fault and link_ok follow one edge after fault_present. Both latched bits react on the edge after a read strobe. The bench drives every input on a falling edge and samples the outputs on the next falling edge, before it changes any input. It then repeats the sampling one falling edge later for the status bits, so each check lands in the exact cycle its result is due. The vector table exercises fault_present alone. The directed tests afterwards probe the one-cycle lag of the status bits and their behaviour under reads.

// File: rtl/fef_pkg.sv
package fef_pkg;

   // Result of one accepted bit as seen by the unit tracker
   typedef enum logic [1:0] {
      EV_NONE = 2'd0,   // no unit boundary on this bit
      EV_GOOD = 2'd1,   // zero closing a run of exactly the code length
      EV_BAD  = 2'd2    // wrong-length run, or overlong run detected
   } unit_ev_e;

endpackage

// File: rtl/fef_run_counter.sv
module fef_run_counter
   import fef_pkg::*;
#(
   parameter int ONES_LEN = 84
) (
   input  logic     clk,
   input  logic     rst,
   input  logic     bit_vld,
   input  logic     bit_in,
   output unit_ev_e ev
);

   localparam int RW = $clog2(ONES_LEN + 2);
   localparam logic [RW-1:0] FULL = RW'(ONES_LEN);
   localparam logic [RW-1:0] OVER = RW'(ONES_LEN + 1);

   logic [RW-1:0] run_q;

   // Saturating count of consecutive accepted ones
   always_ff @(posedge clk) begin
      if (rst) begin
         run_q <= '0;
      end else if (bit_vld) begin
         if (!bit_in)
            run_q <= '0;
         else if (run_q != OVER)
            run_q <= run_q + RW'(1);
      end
   end

   always_comb begin
      ev = EV_NONE;
      if (bit_vld) begin
         if (!bit_in)
            ev = (run_q == FULL) ? EV_GOOD : EV_BAD;
         else if (run_q == FULL)
            ev = EV_BAD;   // this one makes the run overlong
      end
   end

   a_r5_run_bounded: assert property (@(posedge clk) disable iff (rst)
      run_q <= OVER);

   a_r6_idle_holds_run: assert property (@(posedge clk) disable iff (rst)
      !bit_vld |=> $stable(run_q));

endmodule

// File: rtl/fef_unit_tracker.sv
module fef_unit_tracker
   import fef_pkg::*;
#(
   parameter int UNITS_REQ = 3
) (
   input  logic     clk,
   input  logic     rst,
   input  unit_ev_e ev,
   output logic     fault_q
);

   generate
      if (UNITS_REQ == 1) begin : g_single
         // One good unit is enough: no counter needed
         always_ff @(posedge clk) begin
            if (rst)
               fault_q <= 1'b0;
            else if (ev == EV_GOOD)
               fault_q <= 1'b1;
            else if (ev == EV_BAD)
               fault_q <= 1'b0;
         end
      end else begin : g_count
         localparam int UW = $clog2(UNITS_REQ + 1);
         localparam logic [UW-1:0] LAST = UW'(UNITS_REQ - 1);
         localparam logic [UW-1:0] SAT  = UW'(UNITS_REQ);

         logic [UW-1:0] units_q;

         always_ff @(posedge clk) begin
            if (rst) begin
               units_q <= '0;
               fault_q <= 1'b0;
            end else if (ev == EV_GOOD) begin
               if (units_q >= LAST) begin
                  units_q <= SAT;
                  fault_q <= 1'b1;
               end else begin
                  units_q <= units_q + UW'(1);
               end
            end else if (ev == EV_BAD) begin
               units_q <= '0;
               fault_q <= 1'b0;
            end
         end

         a_r3_count_bounded: assert property (@(posedge clk) disable iff (rst)
            units_q <= SAT);
      end
   endgenerate

   a_r4_bad_unit_clears: assert property (@(posedge clk) disable iff (rst)
      ev == EV_BAD |=> !fault_q);

   a_r2_rise_after_good: assert property (@(posedge clk) disable iff (rst)
      $rose(fault_q) |-> $past(ev) == EV_GOOD);

   a_r10_idle_keeps_fault: assert property (@(posedge clk) disable iff (rst)
      ev == EV_NONE |=> $stable(fault_q));

endmodule

// File: rtl/fef_status_latch.sv
module fef_status_latch (
   input  logic clk,
   input  logic rst,
   input  logic fault_in,
   input  logic rd_stb,
   output logic remote_fault,
   output logic link_ok
);

   // Latch-high remote fault: a read clears it only if the fault level is gone.
   // Latch-low link: recovers only on a read while no fault is present.
   always_ff @(posedge clk) begin
      if (rst) begin
         remote_fault <= 1'b0;
         link_ok      <= 1'b0;
      end else begin
         remote_fault <= fault_in | (remote_fault & ~rd_stb);
         link_ok      <= ~fault_in & (link_ok | rd_stb);
      end
   end

   a_r7_fault_sets_rf: assert property (@(posedge clk) disable iff (rst)
      fault_in |=> remote_fault);

   a_r8_rf_held_without_read: assert property (@(posedge clk) disable iff (rst)
      remote_fault && !rd_stb |=> remote_fault);

   a_r9_link_low_in_fault: assert property (@(posedge clk) disable iff (rst)
      fault_in |=> !link_ok);

   a_r9_link_up_on_read: assert property (@(posedge clk) disable iff (rst)
      rd_stb && !fault_in |=> link_ok);

   a_r9_no_rise_without_read: assert property (@(posedge clk) disable iff (rst)
      $rose(link_ok) |-> $past(rd_stb));

endmodule

// File: rtl/fef_detector.sv
module fef_detector
   import fef_pkg::*;
#(
   parameter int ONES_LEN  = 84,
   parameter int UNITS_REQ = 3
) (
   input  logic clk,
   input  logic rst,
   input  logic bit_vld,
   input  logic bit_in,
   input  logic rd_stb,
   output logic fault_present,
   output logic remote_fault,
   output logic link_ok
);

   generate
      if (ONES_LEN < 2) begin : g_bad_len
         $error("fef_detector: ONES_LEN must be at least 2");
      end
      if (UNITS_REQ < 1) begin : g_bad_units
         $error("fef_detector: UNITS_REQ must be at least 1");
      end
   endgenerate

   unit_ev_e ev;

   fef_run_counter #(.ONES_LEN(ONES_LEN)) u_run (
      .clk     (clk),
      .rst     (rst),
      .bit_vld (bit_vld),
      .bit_in  (bit_in),
      .ev      (ev)
   );

   fef_unit_tracker #(.UNITS_REQ(UNITS_REQ)) u_units (
      .clk     (clk),
      .rst     (rst),
      .ev      (ev),
      .fault_q (fault_present)
   );

   fef_status_latch u_stat (
      .clk          (clk),
      .rst          (rst),
      .fault_in     (fault_present),
      .rd_stb       (rd_stb),
      .remote_fault (remote_fault),
      .link_ok      (link_ok)
   );

   a_r6_idle_fault_stable: assert property (@(posedge clk) disable iff (rst)
      !bit_vld |=> $stable(fault_present));

endmodule

// File: tb/tb_fef_detector.sv
`timescale 1ns/1ps
module tb_fef_detector;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic bit_vld = 1'b0;
   logic bit_in = 1'b0;
   logic rd_stb = 1'b0;
   logic fault_present, remote_fault, link_ok;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   fef_detector dut (
      .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in), .rd_stb(rd_stb),
      .fault_present(fault_present), .remote_fault(remote_fault), .link_ok(link_ok)
   );

   // {ones before the zero, expected fault_present after the zero}
   localparam logic [8:0] VEC_TBL [15] = '{
      {8'd84, 1'b0}, {8'd84, 1'b0}, {8'd84, 1'b1}, {8'd84, 1'b1},
      {8'd83, 1'b0}, {8'd84, 1'b0}, {8'd84, 1'b0}, {8'd84, 1'b1},
      {8'd85, 1'b0}, {8'd84, 1'b0}, {8'd84, 1'b0}, {8'd84, 1'b1},
      {8'd0,  1'b0}, {8'd84, 1'b0}, {8'd84, 1'b0}
   };

   task automatic chk(input logic got, input logic exp, input string what);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b at %0t", what, got, exp, $time);
      end
   endtask

   task automatic drive(input logic v, input logic b, input logic rd);
      @(negedge clk);
      bit_vld = v;
      bit_in  = b;
      rd_stb  = rd;
   endtask

   task automatic send_unit(input int ones);
      for (int i = 0; i < ones; i++) drive(1'b1, 1'b1, 1'b0);
      drive(1'b1, 1'b0, 1'b0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      bit_vld = 1'b0; bit_in = 1'b0; rd_stb = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(fault_present, 1'b0, "R1 fault_present in reset");
      chk(remote_fault,  1'b0, "R1 remote_fault in reset");
      chk(link_ok,       1'b0, "R1 link_ok in reset");
      rst = 1'b0;

      // R9: link stays low without a read, rises after one
      repeat (4) drive(1'b0, 1'b0, 1'b0);
      chk(link_ok, 1'b0, "R9 link_ok no rise without read");
      drive(1'b0, 1'b0, 1'b1);
      drive(1'b0, 1'b0, 1'b0);
      chk(link_ok, 1'b1, "R9 link_ok after clean read");

      // Table walk: R2, R3, R4, R5, R10 on fault_present
      for (int k = 0; k < 15; k++) begin
         send_unit(int'(VEC_TBL[k][8:1]));
         drive(1'b0, 1'b0, 1'b0);
         chk(fault_present, VEC_TBL[k][0], $sformatf("R2/R3/R4/R10 vector %0d", k));
      end

      // R2 latency from a clean state
      do_reset();
      drive(1'b0, 1'b0, 1'b1);
      drive(1'b0, 1'b0, 1'b0);
      chk(link_ok, 1'b1, "R9 link up before fault");
      send_unit(84); send_unit(84); send_unit(84);
      drive(1'b0, 1'b0, 1'b0);
      chk(fault_present, 1'b1, "R2 fault_present one edge after third zero");
      chk(remote_fault,  1'b0, "R2 remote_fault not yet set");
      chk(link_ok,       1'b1, "R2 link_ok not yet dropped");
      drive(1'b0, 1'b0, 1'b0);
      chk(remote_fault,  1'b1, "R2 remote_fault one edge later");
      chk(link_ok,       1'b0, "R2 link_ok dropped one edge later");

      // R7: back-to-back reads during fault
      for (int r = 0; r < 3; r++) drive(1'b0, 1'b0, 1'b1);
      drive(1'b0, 1'b0, 1'b0);
      chk(remote_fault, 1'b1, "R7 remote_fault after consecutive reads");
      chk(link_ok,      1'b0, "R9 link_ok not restored by read in fault");

      // R5: the 85th one clears fault_present
      for (int i = 0; i < 84; i++) drive(1'b1, 1'b1, 1'b0);
      drive(1'b0, 1'b0, 1'b0);
      chk(fault_present, 1'b1, "R5 fault held after 84 ones");
      drive(1'b1, 1'b1, 1'b0);
      drive(1'b0, 1'b0, 1'b0);
      chk(fault_present, 1'b0, "R5 fault cleared by 85th one");
      drive(1'b1, 1'b0, 1'b0);

      // R8: remote_fault held until read once fault has gone
      repeat (3) drive(1'b0, 1'b0, 1'b0);
      chk(remote_fault, 1'b1, "R8 remote_fault held without read");
      chk(link_ok,      1'b0, "R9 link_ok still low without read");
      drive(1'b0, 1'b0, 1'b1);
      drive(1'b0, 1'b0, 1'b0);
      chk(remote_fault, 1'b0, "R8 remote_fault cleared by read");
      chk(link_ok,      1'b1, "R9 link_ok restored by read");

      // R6: idle cycles with bit_in toggling do not break units
      do_reset();
      for (int u = 0; u < 3; u++) begin
         for (int i = 0; i < 84; i++) begin
            drive(1'b1, 1'b1, 1'b0);
            if (i % 20 == 7) drive(1'b0, 1'b0, 1'b0);
         end
         drive(1'b0, 1'b1, 1'b0);
         drive(1'b1, 1'b0, 1'b0);
         drive(1'b0, 1'b0, 1'b0);
      end
      chk(fault_present, 1'b1, "R6 fault with idle gaps");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule